// File: doc/BRIEF.md
# Power-Management Register Block with SMI

This block is a small I/O-mapped register file for power-management software. A host reaches it through a dword offset, a 32-bit write bus with four byte enables, and separate read and write strobes. It holds these 16-bit words:

- power status and power enable, which share one dword;
- power control;
- a power timer word that software writes;
- general-purpose event status and enable, which share another dword;
- a global SMI control word.

It also holds a one-byte SMI command port.

The SMI control word is write-one-to-clear. When the command port is written, the block stores the byte and sets a software-SMI pending bit in the control word. The `smi_o` line is a level output. It stays high while any pending bit in the control word is set, and it is re-evaluated on every write to the control word or the command port. Software therefore triggers an SMI by writing the command byte and acknowledges it by writing 1 to the pending bit.

Top module: `pm_smi_regs`

## Requirements
- R1: After reset every register reads 0 and `smi_o` is low.
- R2: Dword offset 0 holds power status in bits 15:0 and power enable in bits 31:16. Each byte is written only when its byte enable (be_i bit n for bits 8n+7:8n) is set.
- R3: At dword offset 1, bits 15:0 hold power control. At dword offset 2, bits 15:0 hold the power timer word. Bits 31:16 of both offsets read 0 and cannot be written.
- R4: Dword offset 8 holds event status in bits 15:0 and event enable in bits 31:16, each written byte by byte.
- R5: At dword offset 0xA, bits 15:0 are global SMI control. A write clears each control bit written as 1 in an enabled byte lane and leaves the other bits unchanged. A read returns the current value.
- R6: At dword offset 0xB, a write with be_i[2] set stores wdata_i[23:16] as the command byte and sets control bit 9 (software-SMI pending). A read of offset 0xB returns the command byte in bits 23:16 and 0 in all other bits.
- R7: After each write to offset 0xA or 0xB, `smi_o` equals the OR of all control bits. It rises after a command write and falls after bit 9 is cleared.
- R8: Writes to any other offset, and writes to lanes that hold no register, change nothing. Reads of those offsets and lanes return 0.
- R9: `rdata_o` holds the addressed dword in the cycle after a clock edge that samples rd_i high, and holds 0 after an edge that samples rd_i low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 4 | Dword offset |
| wdata_i | input | 32 | Write data |
| be_i | input | 4 | Byte enables, bit n covers bits 8n+7:8n |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Registered read data |
| smi_o | output | 1 | SMI level output |

## Verification
A write takes effect at the same clock edge that samples `wr_i`. The register contents and `smi_o` are therefore due one edge after the strobe, and the bench samples them at the following falling edge. Read data is registered, so `rdata_o` is compared at the falling edge after the rising edge that sampled `rd_i`. One falling edge later it is checked again for 0. The bench sweeps every offset against every combination of byte enables with computed data, and compares each result with an arithmetic model of the word and lane rules.

// File: rtl/pm_smi_pkg.sv
package pm_smi_pkg;
  localparam int NUM_HREG   = 6;
  localparam int OFF_SMI_CTL = 10;
  localparam int OFF_SMI_CMD = 11;
  localparam int SW_SMI_BIT = 9;
  localparam int CMD_LANE   = 2;

  // half-word slot -> dword offset
  function automatic int hreg_off(input int idx);
    case (idx)
      0, 1:    return 0;
      2:       return 1;
      3:       return 2;
      default: return 8;
    endcase
  endfunction

  // half-word slot -> upper half of the dword
  function automatic bit hreg_hi(input int idx);
    return (idx == 1) || (idx == 5);
  endfunction
endpackage

// File: rtl/pm_decode.sv
module pm_decode
  import pm_smi_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NUM_HREG-1:0] hsel_o,
  output logic              ctl_sel_o,
  output logic              cmd_sel_o,
  output logic              hit_o
);
  for (genvar g = 0; g < NUM_HREG; g++) begin : g_sel
    assign hsel_o[g] = (addr_i == ADDR_W'(hreg_off(g)));
  end
  assign ctl_sel_o = (addr_i == ADDR_W'(OFF_SMI_CTL));
  assign cmd_sel_o = (addr_i == ADDR_W'(OFF_SMI_CMD));
  assign hit_o     = (|hsel_o) | ctl_sel_o | cmd_sel_o;
endmodule

// File: rtl/pm_hword_reg.sv
module pm_hword_reg #(
  parameter int HW = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [HW/8-1:0] be_i,
  input  logic [HW-1:0]   wdata_i,
  output logic [HW-1:0]   q_o
);
  localparam int NB = HW / 8;
  logic [7:0] byte_q [NB];

  for (genvar b = 0; b < NB; b++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                byte_q[b] <= '0;
      else if (we_i && be_i[b])   byte_q[b] <= wdata_i[b*8 +: 8];
    end
    assign q_o[b*8 +: 8] = byte_q[b];
  end

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_o));
endmodule

// File: rtl/pm_smi_unit.sv
module pm_smi_unit #(
  parameter int HW       = 16,
  parameter int DATA_W   = 32,
  parameter int SW_BIT   = 9,
  parameter int CMD_LANE = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_we_i,
  input  logic              cmd_we_i,
  input  logic [DATA_W/8-1:0] be_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [HW-1:0]     gsmi_o,
  output logic [7:0]        cmd_o,
  output logic              smi_o
);
  localparam int NB = HW / 8;

  logic [HW-1:0] gsmi_q, gsmi_n, clr_mask;
  logic [7:0]    cmd_q;
  logic          smi_q;
  logic          cmd_fire;

  for (genvar b = 0; b < NB; b++) begin : g_clr
    assign clr_mask[b*8 +: 8] = (ctl_we_i && be_i[b]) ? wdata_i[b*8 +: 8] : 8'h00;
  end

  assign cmd_fire = cmd_we_i && be_i[CMD_LANE];

  always_comb begin
    gsmi_n = gsmi_q & ~clr_mask;
    if (cmd_fire) gsmi_n[SW_BIT] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gsmi_q <= '0;
      cmd_q  <= '0;
      smi_q  <= 1'b0;
    end else begin
      gsmi_q <= gsmi_n;
      if (cmd_fire) cmd_q <= wdata_i[CMD_LANE*8 +: 8];
      if (ctl_we_i || cmd_we_i) smi_q <= |gsmi_n;
    end
  end

  assign gsmi_o = gsmi_q;
  assign cmd_o  = cmd_q;
  assign smi_o  = smi_q;

  assert_sw_smi_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_fire |=> (smi_o && gsmi_o[SW_BIT]));
  assert_w1c_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_we_i && be_i[SW_BIT/8] && wdata_i[SW_BIT]) |=> !gsmi_o[SW_BIT]);
  assert_smi_level_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_we_i || cmd_we_i) |=> (smi_o == (gsmi_o != '0)));
  assert_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctl_we_i || cmd_we_i) |=> ($stable(gsmi_o) && $stable(smi_o) && $stable(cmd_o)));
endmodule

// File: rtl/pm_smi_regs.sv
module pm_smi_regs
  import pm_smi_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W/8-1:0] be_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              smi_o
);
  localparam int HW  = DATA_W / 2;
  localparam int HNB = HW / 8;

  logic [NUM_HREG-1:0] hsel;
  logic ctl_sel, cmd_sel, hit;
  logic [HW-1:0] hq [NUM_HREG];
  logic [HW-1:0] gsmi;
  logic [7:0]    cmd;
  logic [DATA_W-1:0] rd_val, rdata_q;

  pm_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i    (addr_i),
    .hsel_o    (hsel),
    .ctl_sel_o (ctl_sel),
    .cmd_sel_o (cmd_sel),
    .hit_o     (hit)
  );

  for (genvar g = 0; g < NUM_HREG; g++) begin : g_hreg
    localparam int LSB = hreg_hi(g) ? HW : 0;
    pm_hword_reg #(.HW(HW)) u_reg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (wr_i && hsel[g]),
      .be_i    (be_i[LSB/8 +: HNB]),
      .wdata_i (wdata_i[LSB +: HW]),
      .q_o     (hq[g])
    );
  end

  pm_smi_unit #(
    .HW(HW), .DATA_W(DATA_W), .SW_BIT(SW_SMI_BIT), .CMD_LANE(CMD_LANE)
  ) u_smi (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ctl_we_i (wr_i && ctl_sel),
    .cmd_we_i (wr_i && cmd_sel),
    .be_i     (be_i),
    .wdata_i  (wdata_i),
    .gsmi_o   (gsmi),
    .cmd_o    (cmd),
    .smi_o    (smi_o)
  );

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NUM_HREG; i++) begin
      if (hsel[i]) rd_val = rd_val | (DATA_W'(hq[i]) << (hreg_hi(i) ? HW : 0));
    end
    if (ctl_sel) rd_val[HW-1:0] = gsmi;
    if (cmd_sel) rd_val[CMD_LANE*8 +: 8] = cmd;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rd_i ? rd_val : '0;
  end
  assign rdata_o = rdata_q;

  assert_rd_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> (rdata_o == '0));
  assert_miss_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !hit) |=> $stable(smi_o));
endmodule

// File: tb/pm_smi_regs_tb.sv
`timescale 1ns/1ps
module pm_smi_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [3:0]  be = '0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [31:0] rdata;
  logic        smi;

  int checks = 0;
  int errors = 0;

  logic [15:0] m_h [6];
  logic [15:0] m_gsmi;
  logic [7:0]  m_cmd;
  logic        m_smi;

  always #2 clk = ~clk;

  pm_smi_regs u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .be_i(be),
    .wr_i(wr), .rd_i(rd), .rdata_o(rdata), .smi_o(smi)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %08h expected %08h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] merge(input logic [15:0] old, input logic [1:0] b, input logic [15:0] d);
    logic [15:0] r = old;
    if (b[0]) r[7:0]  = d[7:0];
    if (b[1]) r[15:8] = d[15:8];
    return r;
  endfunction

  function automatic logic [31:0] model_rd(input int off);
    case (off)
      0:  return {m_h[1], m_h[0]};
      1:  return {16'h0, m_h[2]};
      2:  return {16'h0, m_h[3]};
      8:  return {m_h[5], m_h[4]};
      10: return {16'h0, m_gsmi};
      11: return {8'h0, m_cmd, 16'h0};
      default: return 32'h0;
    endcase
  endfunction

  task automatic do_wr(input int off, input logic [3:0] b, input logic [31:0] d);
    logic [15:0] clr;
    @(negedge clk);
    addr = 4'(off); be = b; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; be = '0;
    case (off)
      0: begin m_h[0] = merge(m_h[0], b[1:0], d[15:0]); m_h[1] = merge(m_h[1], b[3:2], d[31:16]); end
      1: m_h[2] = merge(m_h[2], b[1:0], d[15:0]);
      2: m_h[3] = merge(m_h[3], b[1:0], d[15:0]);
      8: begin m_h[4] = merge(m_h[4], b[1:0], d[15:0]); m_h[5] = merge(m_h[5], b[3:2], d[31:16]); end
      10: begin
        clr = {b[1] ? d[15:8] : 8'h0, b[0] ? d[7:0] : 8'h0};
        m_gsmi = m_gsmi & ~clr;
        m_smi = |m_gsmi;
      end
      11: begin
        if (b[2]) begin m_cmd = d[23:16]; m_gsmi[9] = 1'b1; end
        m_smi = |m_gsmi;
      end
      default: ;
    endcase
    chk("R7 smi_o after write", {31'h0, smi}, {31'h0, m_smi});
  endtask

  task automatic do_rd(input int off, input string req);
    @(negedge clk);
    addr = 4'(off); rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    chk(req, rdata, model_rd(off));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog actual hang expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 6; i++) m_h[i] = '0;
    m_gsmi = '0; m_cmd = '0; m_smi = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 smi_o reset", {31'h0, smi}, 32'h0);
    for (int o = 0; o < 16; o++) do_rd(o, "R1 reset read");

    // R6/R7 software SMI then acknowledge
    do_wr(11, 4'b0100, 32'h00A5_0000);
    chk("R6 pending bit", {31'h0, smi}, 32'h1);
    do_rd(11, "R6 command byte read");
    do_rd(10, "R6 control shows bit 9");
    do_wr(10, 4'b0011, 32'h0000_0000);     // writing zeros keeps pending
    chk("R5 zero write keeps", {31'h0, smi}, 32'h1);
    do_wr(10, 4'b0001, 32'h0000_0200);     // wrong lane for bit 9
    chk("R5 disabled lane keeps", {31'h0, smi}, 32'h1);
    do_wr(10, 4'b0010, 32'h0000_0200);
    chk("R7 smi falls", {31'h0, smi}, 32'h0);
    do_wr(11, 4'b1011, 32'h5500_0000);     // no lane 2: ignored
    chk("R8 cmd lane2 off", {31'h0, smi}, 32'h0);
    do_rd(11, "R8 cmd unchanged");

    // R9 idle read data
    @(negedge clk);
    chk("R9 idle rdata zero", rdata, 32'h0);

    // sweep: every offset x every byte-enable pattern
    for (int o = 0; o < 16; o++) begin
      for (int b = 0; b < 16; b++) begin
        logic [31:0] d;
        d = 32'h9E37_79B9 * (o * 16 + b + 1);
        do_wr(o, 4'(b), d);
        case (o)
          0: do_rd(o, "R2 sweep");
          1, 2: do_rd(o, "R3 sweep");
          8: do_rd(o, "R4 sweep");
          10: do_rd(o, "R5 sweep");
          11: do_rd(o, "R6 sweep");
          default: do_rd(o, "R8 sweep");
        endcase
      end
      // R8: nothing else moved
      for (int k = 0; k < 16; k++) do_rd(k, "R8 cross check");
    end
    @(negedge clk);
    chk("R9 rdata idle end", rdata, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule